// File: doc/BRIEF.md
# Dual-View Aliased Register File

This block holds eight 80-bit entries that two execution views share. The floating-point view treats the entries as a circular stack. A 3-bit top pointer selects the base entry, and every register index in this view is added to that pointer. Push and pop commands move the pointer. The integer SIMD view sees the same storage as eight fixed 64-bit registers: register n is always entry n, and the top pointer plays no part. Each view has one read port and one write port. Reads are combinational. Writes take effect on the rising clock edge.

The two views are aliased, so a value written in one view is visible in the other. A SIMD write fills bits 79:64 of the target entry with ones, so the floating-point view sees a NaN or infinity pattern there. Every SIMD write also returns the top pointer to zero and marks all entries valid. Each entry has one valid bit, and this bit drives a stack-fault output on floating-point reads. A mode-switch command resets the pointer without touching any data. An empty command clears all valid bits.

The entry count must be a power of two, because the stack index wraps modulo the entry count.

Top module: `alias_regfile`

## Requirements
- R1: After reset, the top pointer is 0, all valid bits are 0, and every entry reads as zero in both views.
- R2: A SIMD write to register n stores the 64-bit data in bits 63:0 of entry n, whatever the top pointer is. A SIMD read of register n returns bits 63:0 of entry n.
- R3: A SIMD write sets bits 79:64 of the target entry to 16'hFFFF, and a floating-point read of that entry shows them.
- R4: A floating-point read or write of index i addresses physical entry (top + i) mod 8, using the top pointer that holds before the clock edge.
- R5: A push decrements the top pointer and a pop increments it, both modulo 8. A push and a pop in the same cycle leave the pointer and all valid bits unchanged.
- R6: A SIMD write sets the top pointer to 0 and sets all eight valid bits, overriding a push or pop in the same cycle.
- R7: The mode-switch input sets the top pointer to 0, overrides a push or pop in the same cycle, and leaves the stored data unchanged.
- R8: The empty input clears all valid bits and leaves the data unchanged. A SIMD write in the same cycle wins, and all valid bits end up set.
- R9: With read enable high, fp_fault_o is 1 exactly when the addressed physical entry is not valid. A floating-point write marks its entry valid. A lone pop clears the valid bit of the entry at the current top.
- R10: A floating-point write to an entry changes what the SIMD view reads from that physical entry: the SIMD read returns bits 63:0 of the written value.
- R11: A read of an entry that is being written in the same cycle returns the old contents. The new value appears after the clock edge.
- R12: When both views write the same physical entry in one cycle, the SIMD write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_rd_en_i | input | 1 | Floating-point read enable, used only for fault detection |
| fp_rd_idx_i | input | 3 | Floating-point read index, relative to the top pointer |
| fp_rd_data_o | output | 80 | Floating-point read data |
| fp_fault_o | output | 1 | Stack fault: an enabled read addresses an invalid entry |
| fp_wr_en_i | input | 1 | Floating-point write enable |
| fp_wr_idx_i | input | 3 | Floating-point write index, relative to the top pointer |
| fp_wr_data_i | input | 80 | Floating-point write data |
| fp_push_i | input | 1 | Decrement the top pointer |
| fp_pop_i | input | 1 | Increment the top pointer and free the current top entry |
| simd_rd_idx_i | input | 3 | SIMD read register number |
| simd_rd_data_o | output | 64 | SIMD read data |
| simd_wr_en_i | input | 1 | SIMD write enable |
| simd_wr_idx_i | input | 3 | SIMD write register number |
| simd_wr_data_i | input | 64 | SIMD write data |
| mode_sw_i | input | 1 | Mode switch; resets the top pointer |
| empty_i | input | 1 | Mark all entries empty |
| top_o | output | 3 | Current top pointer |
| valid_o | output | 8 | Per-entry valid bits |

## Verification
The bench moves the top pointer to values other than zero (7, 6 and a wrap from 0 to 7) before it writes through either view. This separates fixed SIMD addressing from stack-relative addressing, and shows whether the floating-point index is added to the pointer or used as a raw entry number. Cross-view patterns write in one view and read the same physical entry in the other. These tell apart correct aliasing, a missing fill of the upper ones, and a wrong index mapping. Same-cycle combinations cover overlapping commands: push with pop, empty with a SIMD write, mode switch with push, and two writes to one entry. Each combination shows whether the documented priority is applied. Reads taken before the clock edge of a pending write separate old data from new data.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  localparam int unsigned DEF_NUM_REGS = 8;
  localparam int unsigned DEF_FP_W     = 80;
  localparam int unsigned DEF_INT_W    = 64;

  typedef enum logic [1:0] {
    TOS_HOLD  = 2'd0,
    TOS_PUSH  = 2'd1,
    TOS_POP   = 2'd2,
    TOS_CLEAR = 2'd3
  } tos_op_e;
endpackage

// File: rtl/alias_rf_tos.sv
module alias_rf_tos
  import alias_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tos_op_e          op_i,
  output logic [IDX_W-1:0] top_o
);
  logic [IDX_W-1:0] top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
    end else begin
      unique case (op_i)
        TOS_PUSH:  top_q <= top_q - 1'b1;
        TOS_POP:   top_q <= top_q + 1'b1;
        TOS_CLEAR: top_q <= '0;
        default:   top_q <= top_q;
      endcase
    end
  end

  assign top_o = top_q;

  assert_push_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == TOS_PUSH |=> top_q == $past(top_q) - 1'b1);
  assert_pop_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == TOS_POP |=> top_q == $past(top_q) + 1'b1);
  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == TOS_CLEAR |=> top_q == '0);
  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == TOS_HOLD |=> $stable(top_q));
endmodule

// File: rtl/alias_rf_tags.sv
module alias_rf_tags
  import alias_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_all_i,
  input  logic                clr_all_i,
  input  logic                fp_set_en_i,
  input  logic [IDX_W-1:0]    fp_set_idx_i,
  input  logic                pop_clr_en_i,
  input  logic [IDX_W-1:0]    pop_clr_idx_i,
  output logic [NUM_REGS-1:0] valid_o
);
  logic [NUM_REGS-1:0] valid_q;

  // priority: set_all > clr_all > fp write > pop
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_tag
    logic fp_hit, pop_hit;
    assign fp_hit  = fp_set_en_i  && (fp_set_idx_i  == IDX_W'(g));
    assign pop_hit = pop_clr_en_i && (pop_clr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        valid_q[g] <= 1'b0;
      else if (set_all_i) valid_q[g] <= 1'b1;
      else if (clr_all_i) valid_q[g] <= 1'b0;
      else if (fp_hit)    valid_q[g] <= 1'b1;
      else if (pop_hit)   valid_q[g] <= 1'b0;
    end
  end

  assign valid_o = valid_q;

  assert_set_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_all_i |=> &valid_q);
  assert_clr_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i && !set_all_i |=> valid_q == '0);
  assert_fp_mark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_set_en_i && !clr_all_i |=> valid_q[$past(fp_set_idx_i)]);
  assert_quiet_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_all_i && !clr_all_i && !fp_set_en_i && !pop_clr_en_i |=> $stable(valid_q));
endmodule

// File: rtl/alias_rf_array.sv
module alias_rf_array
  import alias_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned FP_W     = DEF_FP_W,
  parameter int unsigned INT_W    = DEF_INT_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned HI_W    = FP_W - INT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_we_i,
  input  logic [IDX_W-1:0] fp_widx_i,
  input  logic [FP_W-1:0]  fp_wdata_i,
  input  logic             simd_we_i,
  input  logic [IDX_W-1:0] simd_widx_i,
  input  logic [INT_W-1:0] simd_wdata_i,
  input  logic [IDX_W-1:0] fp_ridx_i,
  output logic [FP_W-1:0]  fp_rdata_o,
  input  logic [IDX_W-1:0] simd_ridx_i,
  output logic [INT_W-1:0] simd_rdata_o
);
  logic [FP_W-1:0] mem_q [NUM_REGS];
  logic [FP_W-1:0] simd_word;

  assign simd_word = {{HI_W{1'b1}}, simd_wdata_i};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic fp_hit, simd_hit;
    assign fp_hit   = fp_we_i   && (fp_widx_i   == IDX_W'(g));
    assign simd_hit = simd_we_i && (simd_widx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mem_q[g] <= '0;
      else if (simd_hit) mem_q[g] <= simd_word;
      else if (fp_hit)   mem_q[g] <= fp_wdata_i;
    end
  end

  assign fp_rdata_o   = mem_q[fp_ridx_i];
  assign simd_rdata_o = mem_q[simd_ridx_i][INT_W-1:0];

  assert_simd_hi_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simd_we_i |=> &mem_q[$past(simd_widx_i)][FP_W-1:INT_W]);
  assert_simd_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simd_we_i && fp_we_i && simd_widx_i == fp_widx_i
    |=> mem_q[$past(simd_widx_i)][INT_W-1:0] == $past(simd_wdata_i));
  assert_fp_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_we_i && !(simd_we_i && simd_widx_i == fp_widx_i)
    |=> mem_q[$past(fp_widx_i)] == $past(fp_wdata_i));
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned FP_W     = DEF_FP_W,
  parameter int unsigned INT_W    = DEF_INT_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fp_rd_en_i,
  input  logic [IDX_W-1:0]    fp_rd_idx_i,
  output logic [FP_W-1:0]     fp_rd_data_o,
  output logic                fp_fault_o,
  input  logic                fp_wr_en_i,
  input  logic [IDX_W-1:0]    fp_wr_idx_i,
  input  logic [FP_W-1:0]     fp_wr_data_i,
  input  logic                fp_push_i,
  input  logic                fp_pop_i,
  input  logic [IDX_W-1:0]    simd_rd_idx_i,
  output logic [INT_W-1:0]    simd_rd_data_o,
  input  logic                simd_wr_en_i,
  input  logic [IDX_W-1:0]    simd_wr_idx_i,
  input  logic [INT_W-1:0]    simd_wr_data_i,
  input  logic                mode_sw_i,
  input  logic                empty_i,
  output logic [IDX_W-1:0]    top_o,
  output logic [NUM_REGS-1:0] valid_o
);
  tos_op_e             tos_op;
  logic [IDX_W-1:0]    top;
  logic [IDX_W-1:0]    fp_rd_phys, fp_wr_phys;
  logic [NUM_REGS-1:0] valid;
  logic                lone_pop;

  // stack-relative to physical; wraps because NUM_REGS is a power of two
  assign fp_rd_phys = top + fp_rd_idx_i;
  assign fp_wr_phys = top + fp_wr_idx_i;
  assign lone_pop   = fp_pop_i && !fp_push_i;

  always_comb begin
    if (simd_wr_en_i || mode_sw_i)  tos_op = TOS_CLEAR;
    else if (fp_push_i && !fp_pop_i) tos_op = TOS_PUSH;
    else if (lone_pop)               tos_op = TOS_POP;
    else                             tos_op = TOS_HOLD;
  end

  alias_rf_tos #(.NUM_REGS(NUM_REGS)) u_tos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (tos_op),
    .top_o (top)
  );

  alias_rf_tags #(.NUM_REGS(NUM_REGS)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_all_i    (simd_wr_en_i),
    .clr_all_i    (empty_i),
    .fp_set_en_i  (fp_wr_en_i),
    .fp_set_idx_i (fp_wr_phys),
    .pop_clr_en_i (lone_pop),
    .pop_clr_idx_i(top),
    .valid_o      (valid)
  );

  alias_rf_array #(.NUM_REGS(NUM_REGS), .FP_W(FP_W), .INT_W(INT_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fp_we_i     (fp_wr_en_i),
    .fp_widx_i   (fp_wr_phys),
    .fp_wdata_i  (fp_wr_data_i),
    .simd_we_i   (simd_wr_en_i),
    .simd_widx_i (simd_wr_idx_i),
    .simd_wdata_i(simd_wr_data_i),
    .fp_ridx_i   (fp_rd_phys),
    .fp_rdata_o  (fp_rd_data_o),
    .simd_ridx_i (simd_rd_idx_i),
    .simd_rdata_o(simd_rd_data_o)
  );

  assign fp_fault_o = fp_rd_en_i && !valid[fp_rd_phys];
  assign top_o      = top;
  assign valid_o    = valid;

  assert_fault_needs_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_fault_o |-> fp_rd_en_i);
  assert_simd_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simd_wr_en_i |=> (simd_rd_idx_i != $past(simd_wr_idx_i))
                     || (simd_rd_data_o == $past(simd_wr_data_i)));
  assert_simd_resets_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simd_wr_en_i |=> top_o == '0 && &valid_o);
  assert_mode_keeps_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_sw_i && !simd_wr_en_i && !fp_wr_en_i && simd_rd_idx_i == $past(simd_rd_idx_i)
    |-> $stable(simd_rd_data_o));
endmodule

// File: tb/alias_regfile_tb.sv
`timescale 1ns/1ps
module alias_regfile_tb;
  logic        clk = 0;
  logic        rst_n;
  logic        fp_rd_en, fp_wr_en, fp_push, fp_pop, simd_wr_en, mode_sw, empty;
  logic [2:0]  fp_rd_idx, fp_wr_idx, simd_rd_idx, simd_wr_idx, top;
  logic [79:0] fp_wr_data, fp_rd_data;
  logic [63:0] simd_wr_data, simd_rd_data;
  logic        fp_fault;
  logic [7:0]  valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alias_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fp_rd_en_i(fp_rd_en), .fp_rd_idx_i(fp_rd_idx), .fp_rd_data_o(fp_rd_data),
    .fp_fault_o(fp_fault),
    .fp_wr_en_i(fp_wr_en), .fp_wr_idx_i(fp_wr_idx), .fp_wr_data_i(fp_wr_data),
    .fp_push_i(fp_push), .fp_pop_i(fp_pop),
    .simd_rd_idx_i(simd_rd_idx), .simd_rd_data_o(simd_rd_data),
    .simd_wr_en_i(simd_wr_en), .simd_wr_idx_i(simd_wr_idx), .simd_wr_data_i(simd_wr_data),
    .mode_sw_i(mode_sw), .empty_i(empty), .top_o(top), .valid_o(valid)
  );

  localparam logic [63:0] D1 = 64'h1122_3344_5566_7788;
  localparam logic [63:0] D2 = 64'hDEAD_BEEF_0BAD_F00D;
  localparam logic [63:0] D3 = 64'h0F0F_1E1E_2D2D_3C3C;
  localparam logic [79:0] F1 = 80'h1234_0000_AAAA_5555_CCCC;
  localparam logic [79:0] F2 = 80'h4000_8000_0000_0000_0001;
  localparam logic [79:0] F3 = 80'h7FFE_1111_2222_3333_4444;

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fp_rd_en = 0; fp_wr_en = 0; fp_push = 0; fp_pop = 0;
    simd_wr_en = 0; mode_sw = 0; empty = 0;
    fp_rd_idx = 0; fp_wr_idx = 0; simd_rd_idx = 0; simd_wr_idx = 0;
    fp_wr_data = '0; simd_wr_data = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic t_reset();
    chk("R1 top", 80'(top), 80'd0);
    chk("R1 valid", 80'(valid), 80'd0);
    simd_rd_idx = 5; fp_rd_idx = 2; #0.5;
    chk("R1 simd read", 80'(simd_rd_data), 80'd0);
    chk("R1 fp read", fp_rd_data, 80'd0);
  endtask

  task automatic t_push_pop();
    fp_push = 1; tick(); chk("R5 push wrap", 80'(top), 80'd7);
    fp_push = 1; tick(); chk("R5 push", 80'(top), 80'd6);
    fp_pop = 1;  tick(); chk("R5 pop", 80'(top), 80'd7);
    fp_push = 1; fp_pop = 1; tick();
    chk("R5 push+pop top", 80'(top), 80'd7);
    chk("R5 push+pop valid", 80'(valid), 80'd0);
  endtask

  task automatic t_simd_write();
    simd_wr_en = 1; simd_wr_idx = 3; simd_wr_data = D1; fp_push = 1;
    simd_rd_idx = 3; #0.5;
    chk("R11 simd old data", 80'(simd_rd_data), 80'd0);
    tick();
    chk("R6 top cleared", 80'(top), 80'd0);
    chk("R6 all valid", 80'(valid), 80'hFF);
    simd_rd_idx = 3; fp_rd_idx = 3; #0.5;
    chk("R2 simd readback", 80'(simd_rd_data), 80'(D1));
    chk("R3 upper ones", fp_rd_data, {16'hFFFF, D1});
  endtask

  task automatic t_fp_alias();
    fp_push = 1; tick();
    fp_wr_en = 1; fp_wr_idx = 4; fp_wr_data = F1; fp_rd_idx = 4; #0.5;
    chk("R11 fp old data", fp_rd_data, {16'hFFFF, D1});
    tick();
    simd_rd_idx = 3; fp_rd_idx = 4; fp_rd_en = 1; #0.5;
    chk("R10 simd sees fp write", 80'(simd_rd_data), 80'(F1[63:0]));
    chk("R4 fp relative read", fp_rd_data, F1);
    chk("R9 no fault valid", 80'(fp_fault), 80'd0);
  endtask

  task automatic t_pop_fault();
    fp_pop = 1; tick();
    chk("R9 pop frees top", 80'(valid), 80'h7F);
    chk("R5 pop to zero", 80'(top), 80'd0);
    fp_rd_en = 1; fp_rd_idx = 7; #0.5;
    chk("R9 fault on empty", 80'(fp_fault), 80'd1);
    fp_rd_idx = 0; #0.5;
    chk("R9 no fault", 80'(fp_fault), 80'd0);
    idle();
    fp_wr_en = 1; fp_wr_idx = 7; fp_wr_data = F2; tick();
    fp_rd_en = 1; fp_rd_idx = 7; #0.5;
    chk("R9 write marks valid", 80'(fp_fault), 80'd0);
    chk("R4 fp write idx7", fp_rd_data, F2);
  endtask

  task automatic t_empty();
    empty = 1; tick();
    chk("R8 empty clears", 80'(valid), 80'd0);
    simd_rd_idx = 3; fp_rd_en = 1; fp_rd_idx = 3; #0.5;
    chk("R8 data kept", 80'(simd_rd_data), 80'(F1[63:0]));
    chk("R9 fault after empty", 80'(fp_fault), 80'd1);
    idle();
    empty = 1; simd_wr_en = 1; simd_wr_idx = 0; simd_wr_data = D2; tick();
    chk("R8 simd wins over empty", 80'(valid), 80'hFF);
  endtask

  task automatic t_mode();
    fp_push = 1; tick();
    chk("R5 push", 80'(top), 80'd7);
    mode_sw = 1; fp_push = 1; tick();
    chk("R7 mode clears top", 80'(top), 80'd0);
    simd_rd_idx = 0; #0.5;
    chk("R7 data unchanged", 80'(simd_rd_data), 80'(D2));
  endtask

  task automatic t_conflict();
    fp_wr_en = 1; fp_wr_idx = 5; fp_wr_data = F3;
    simd_wr_en = 1; simd_wr_idx = 5; simd_wr_data = D3; tick();
    fp_rd_idx = 5; #0.5;
    chk("R12 simd wins", fp_rd_data, {16'hFFFF, D3});
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    idle();
    t_push_pop();
    t_simd_write();
    idle();
    t_fp_alias();
    idle();
    t_pop_fault();
    idle();
    t_empty();
    t_mode();
    idle();
    t_conflict();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule